// File: doc/BRIEF.md
# Far Fetch-and-Add Cache Stage

This block is one level of a cache hierarchy that executes atomic fetch-and-add requests at the place where the data already sits, instead of migrating the line to the requesting core. Each request carries a byte address, an operand size and an addend. In cache mode the stage looks up a direct-mapped tag array. When it owns the line in a writeable state, it performs the add in place and returns the previous value. When it only holds a readable copy, it drops that copy and sends the request outward. When it misses, it sends the request outward without allocating.

With `MEM_CTRL` set, the same block acts as the last stop in front of backing storage. Every request first broadcasts a coherence invalidate for its address. The stage then waits for the completion, which can carry a dirty word written back by another cache. Only after that does it perform the add on the stored word. Requests are taken one at a time, so service follows arrival order. After reset, both modes walk their storage once to load a deterministic starting image. This stands in for the contents that earlier traffic would have left behind.

Top module: `amo_fadd_stage`

## Requirements
- R1: After reset, `req_ready` stays low while the stage loads its starting image, one entry per cycle. With the default parameters this takes 64 cycles.
  - The pattern function is pattern(i) = ((i+1) * 0x0123456789ABCDEF) mod 2^64.
  - Cache mode: set s gets tag s and line state (s mod 4), encoded 0 invalid, 1 shared, 2 exclusive, 3 modified. Word w of set s gets pattern(s*LINE_WORDS + w).
  - Memory-controller mode: word i gets pattern(i).
  - When the walk ends, `req_ready` goes high.
- R2: In cache mode the address fields are decoded as follows: byte = addr[2:0], word = addr[4:3], set = addr[8:5], tag = addr[15:9]. A request whose tag matches a line in state exclusive or modified is a writeable hit. A writeable hit adds the addend to the addressed field, writes the sum back into the line and returns the field's previous value on `rsp_data`. No forward is issued for a writeable hit.
- R3: The size codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. The field starts at addr[2:0] rounded down to a multiple of the size in bytes. The sum wraps modulo the field width. Bytes outside the field are unchanged. The returned old value is zero-extended.
- R4: A line that has been updated by an add stays writeable, so a later add to that line is serviced locally and sees the updated value.
- R5: A tag match on a shared line forwards the request outward with address, size and addend unchanged, and invalidates the local copy. A later request to that line is treated as a miss.
- R6: A miss forwards the request unchanged and allocates nothing, so repeating the request forwards it again.
- R7: The data of the response that the outer level returns on `up_data` is passed back unchanged on `rsp_data`.
- R8: One operation is in flight at a time. `req_ready` stays low from the acceptance of a request until its response has been taken.
- R9: Once `fwd_valid` or `rsp_valid` is raised, it stays high with a stable payload until the matching ready accepts it.
- R10: In memory-controller mode, each request first raises `inv_valid` with the request address. No response is produced until a completion arrives on `done_valid`. If the completion has `done_dirty` set, `done_data` replaces the stored word before the add.
- R11: In memory-controller mode the add is applied to the backing word at index addr[8:3] and the old value is returned. Requests are serviced in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Atomic request offered |
| req_ready | output | 1 | Stage can take a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Operand size code |
| req_addend | input | 64 | Value to add |
| fwd_valid | output | 1 | Request sent to the outer level |
| fwd_ready | input | 1 | Outer level takes the request |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_size | output | 2 | Forwarded size code |
| fwd_addend | output | 64 | Forwarded addend |
| up_valid | input | 1 | Response from the outer level |
| up_ready | output | 1 | Stage can take the outer response |
| up_data | input | 64 | Old value returned from outward |
| inv_valid | output | 1 | Coherence invalidate issued (memory-controller mode) |
| inv_ready | input | 1 | Invalidate accepted |
| inv_addr | output | ADDR_W | Address being invalidated |
| done_valid | input | 1 | Invalidate completed |
| done_dirty | input | 1 | Completion carries a written-back word |
| done_data | input | 64 | Written-back word |
| rsp_valid | output | 1 | Response to the requester |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 64 | Zero-extended old value |

## Verification
A wrong line state shows at the ports on the next access to that line. The symptom is either a forward where a local response was due, or a local response where a forward was due. A line dropped too early is caught by a repeated add to an exclusive line. A missed invalidation is caught by repeating a request to a shared line. A corrupted data word or a mis-aligned field shows as a wrong old value on the next add that touches those bytes. The bench keeps its own copy of every line and word, so such a value is caught within one transaction. Ordering faults in memory-controller mode show up as an early response, or as a dirty word that never reaches the returned value.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_state_e;

  typedef enum logic [3:0] {
    ST_INIT = 4'd0,
    ST_IDLE = 4'd1,
    ST_INV  = 4'd2,
    ST_INVW = 4'd3,
    ST_RD   = 4'd4,
    ST_EVAL = 4'd5,
    ST_FWD  = 4'd6,
    ST_WAIT = 4'd7,
    ST_RSP  = 4'd8
  } stage_fsm_e;

  localparam logic [DATA_W-1:0] PRELOAD_MUL = 64'h0123_4567_89AB_CDEF;

  function automatic logic [DATA_W-1:0] preload_word(input logic [31:0] idx);
    return 64'(idx + 32'd1) * PRELOAD_MUL;
  endfunction

  function automatic logic line_writeable(input logic [1:0] st);
    return (st == LS_EXC) || (st == LS_MOD);
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/amo_word_ram.sv
module amo_word_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // single write port, registered read port: maps onto a simple dual-port block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/amo_sized_add.sv
module amo_sized_add
  import amo_pkg::*;
(
  input  logic [DATA_W-1:0] word_in,
  input  logic [2:0]        byte_off,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] addend,
  output logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] new_word
);

  logic [2:0]        aligned;
  logic [5:0]        shamt;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] field;
  logic [DATA_W-1:0] sum;

  always_comb begin
    fmask    = size_mask(size);
    // round the byte offset down to the operand's natural alignment
    aligned  = byte_off & ~((3'd1 << size) - 3'd1);
    shamt    = {aligned, 3'b000};
    field    = (word_in >> shamt) & fmask;
    sum      = (field + addend) & fmask;
    old_val  = field;
    new_word = (word_in & ~(fmask << shamt)) | (sum << shamt);
  end

endmodule

// File: rtl/amo_fadd_stage.sv
module amo_fadd_stage
  import amo_pkg::*;
#(
  parameter bit MEM_CTRL   = 1'b0,
  parameter int ADDR_W     = 16,
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int MEM_WORDS  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_addend,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [1:0]        fwd_size,
  output logic [63:0]       fwd_addend,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [63:0]       up_data,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [ADDR_W-1:0] inv_addr,
  input  logic              done_valid,
  input  logic              done_dirty,
  input  logic [63:0]       done_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_data
);

  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - 3 - WOFF_W - SET_W;
  localparam int MIDX_W = $clog2(MEM_WORDS);
  localparam int DDEPTH = MEM_CTRL ? MEM_WORDS : NUM_LINES * LINE_WORDS;
  localparam int DIDX_W = $clog2(DDEPTH);
  localparam logic [DIDX_W-1:0] INIT_LAST = DIDX_W'(DDEPTH - 1);

  stage_fsm_e          state_q;
  logic [ADDR_W-1:0]   q_addr;
  logic [1:0]          q_size;
  logic [DATA_W-1:0]   q_addend;
  logic [DATA_W-1:0]   rsp_q;
  logic [DIDX_W-1:0]   init_cnt;

  logic [DIDX_W-1:0]   d_idx;
  logic                look_hit;
  logic                look_wr;
  logic                wb_we;
  logic                d_we;
  logic [DIDX_W-1:0]   d_waddr;
  logic [DATA_W-1:0]   d_wdata;
  logic [DATA_W-1:0]   d_rdata;
  logic [DATA_W-1:0]   add_old;
  logic [DATA_W-1:0]   add_new;
  logic                in_init;
  logic                eval_local;

  assign in_init    = (state_q == ST_INIT);
  assign eval_local = (state_q == ST_EVAL) && look_hit && look_wr;

  // ---------------- control sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_INIT;
      init_cnt <= '0;
      q_addr   <= '0;
      q_size   <= '0;
      q_addend <= '0;
      rsp_q    <= '0;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == INIT_LAST) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            q_addr   <= req_addr;
            q_size   <= req_size;
            q_addend <= req_addend;
            state_q  <= MEM_CTRL ? ST_INV : ST_RD;
          end
        end
        ST_INV:  if (inv_ready) state_q <= ST_INVW;
        ST_INVW: if (done_valid) state_q <= ST_RD;
        ST_RD:   state_q <= ST_EVAL;
        ST_EVAL: begin
          if (look_hit && look_wr) begin
            rsp_q   <= add_old;
            state_q <= ST_RSP;
          end else begin
            state_q <= ST_FWD;
          end
        end
        ST_FWD:  if (fwd_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (up_valid) begin
            rsp_q   <= up_data;
            state_q <= ST_RSP;
          end
        end
        ST_RSP:  if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign fwd_valid  = (state_q == ST_FWD);
  assign up_ready   = (state_q == ST_WAIT);
  assign inv_valid  = (state_q == ST_INV);
  assign rsp_valid  = (state_q == ST_RSP);
  assign fwd_addr   = q_addr;
  assign fwd_size   = q_size;
  assign fwd_addend = q_addend;
  assign inv_addr   = q_addr;
  assign rsp_data   = rsp_q;

  // ---------------- data storage ----------------
  always_comb begin
    d_we    = in_init || eval_local || wb_we;
    d_waddr = in_init ? init_cnt : d_idx;
    if (in_init)    d_wdata = preload_word(32'(init_cnt));
    else if (wb_we) d_wdata = done_data;
    else            d_wdata = add_new;
  end

  amo_word_ram #(.DEPTH(DDEPTH), .WIDTH(DATA_W)) u_data (
    .clk   (clk),
    .we    (d_we),
    .waddr (d_waddr),
    .wdata (d_wdata),
    .raddr (d_idx),
    .rdata (d_rdata)
  );

  amo_sized_add u_add (
    .word_in  (d_rdata),
    .byte_off (q_addr[2:0]),
    .size     (q_size),
    .addend   (q_addend),
    .old_val  (add_old),
    .new_word (add_new)
  );

  // ---------------- mode-specific lookup ----------------
  generate
    if (MEM_CTRL) begin : g_mc
      logic unused_mc;
      logic chk_done_seen;

      assign d_idx     = q_addr[3 +: MIDX_W];
      assign look_hit  = 1'b1;
      assign look_wr   = 1'b1;
      assign wb_we     = (state_q == ST_INVW) && done_valid && done_dirty;
      assign unused_mc = ^{fwd_ready, up_valid, up_data, q_addr};

      always_ff @(posedge clk) begin
        if (rst)                           chk_done_seen <= 1'b0;
        else if (req_valid && req_ready)   chk_done_seen <= 1'b0;
        else if (inv_ready == 1'b0 && done_valid && !inv_valid) chk_done_seen <= 1'b1;
      end

      AST_ADD_AFTER_INVALIDATE: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> chk_done_seen) else $error("response before invalidate completed"); // R10
      AST_MC_NEVER_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !fwd_valid) else $error("memory controller forwarded a request"); // R11
    end else begin : g_cache
      logic [SET_W-1:0]       q_set;
      logic [WOFF_W-1:0]      q_word;
      logic [TAG_W-1:0]       q_tag;
      logic [SET_W-1:0]       init_set;
      logic                   tag_we;
      logic [SET_W-1:0]       tag_waddr;
      logic [TAG_W+1:0]       tag_wdata;
      logic [TAG_W+1:0]       tag_rdata;
      logic                   unused_c;

      assign q_word   = q_addr[3 +: WOFF_W];
      assign q_set    = q_addr[3 + WOFF_W +: SET_W];
      assign q_tag    = q_addr[ADDR_W-1 -: TAG_W];
      assign init_set = init_cnt[DIDX_W-1 -: SET_W];
      assign d_idx    = {q_set, q_word};
      assign wb_we    = 1'b0;
      assign unused_c = ^{inv_ready, done_valid, done_dirty, done_data};

      assign look_hit = (tag_rdata[1:0] != LS_INV) && (tag_rdata[TAG_W+1:2] == q_tag);
      assign look_wr  = line_writeable(tag_rdata[1:0]);

      always_comb begin
        tag_we    = (in_init && (init_cnt[WOFF_W-1:0] == '0)) ||
                    ((state_q == ST_EVAL) && look_hit);
        tag_waddr = in_init ? init_set : q_set;
        if (in_init) tag_wdata = {TAG_W'(init_set), init_set[1:0]};
        else         tag_wdata = {q_tag, look_wr ? LS_MOD : LS_INV};
      end

      amo_word_ram #(.DEPTH(NUM_LINES), .WIDTH(TAG_W + 2)) u_tags (
        .clk   (clk),
        .we    (tag_we),
        .waddr (tag_waddr),
        .wdata (tag_wdata),
        .raddr (q_set),
        .rdata (tag_rdata)
      );
    end
  endgenerate

  // ---------------- protocol checks ----------------
  AST_FWD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_size) && $stable(fwd_addend))
    else $error("forward dropped or changed"); // R9
  AST_RSP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data))
    else $error("response dropped or changed"); // R9
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(fwd_valid || rsp_valid || inv_valid || up_ready))
    else $error("request taken while busy"); // R8
  AST_OUTER_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    up_valid && up_ready |=> rsp_valid && (rsp_data == $past(up_data)))
    else $error("outer response altered"); // R7
  AST_OLD_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    eval_local |=> rsp_valid && ((rsp_data & ~size_mask(fwd_size)) == '0))
    else $error("old value not zero-extended"); // R3

endmodule

// File: tb/amo_fadd_stage_tb_top.sv
module amo_fadd_stage_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // cache-mode DUT signals
  logic c_req_valid = 0, c_req_ready;
  logic [15:0] c_req_addr = '0;
  logic [1:0] c_req_size = '0;
  logic [63:0] c_req_addend = '0;
  logic c_fwd_valid, c_fwd_ready = 0;
  logic [15:0] c_fwd_addr;
  logic [1:0] c_fwd_size;
  logic [63:0] c_fwd_addend;
  logic c_up_valid = 0, c_up_ready;
  logic [63:0] c_up_data = '0;
  logic c_inv_valid;
  logic [15:0] c_inv_addr;
  logic c_rsp_valid, c_rsp_ready = 0;
  logic [63:0] c_rsp_data;

  // memory-controller DUT signals
  logic m_req_valid = 0, m_req_ready;
  logic [15:0] m_req_addr = '0;
  logic [1:0] m_req_size = '0;
  logic [63:0] m_req_addend = '0;
  logic m_fwd_valid;
  logic [15:0] m_fwd_addr;
  logic [1:0] m_fwd_size;
  logic [63:0] m_fwd_addend;
  logic m_up_ready;
  logic m_inv_valid, m_inv_ready = 0;
  logic [15:0] m_inv_addr;
  logic m_done_valid = 0, m_done_dirty = 0;
  logic [63:0] m_done_data = '0;
  logic m_rsp_valid, m_rsp_ready = 0;
  logic [63:0] m_rsp_data;

  amo_fadd_stage #(.MEM_CTRL(1'b0)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(c_req_valid), .req_ready(c_req_ready), .req_addr(c_req_addr),
    .req_size(c_req_size), .req_addend(c_req_addend),
    .fwd_valid(c_fwd_valid), .fwd_ready(c_fwd_ready), .fwd_addr(c_fwd_addr),
    .fwd_size(c_fwd_size), .fwd_addend(c_fwd_addend),
    .up_valid(c_up_valid), .up_ready(c_up_ready), .up_data(c_up_data),
    .inv_valid(c_inv_valid), .inv_ready(1'b0), .inv_addr(c_inv_addr),
    .done_valid(1'b0), .done_dirty(1'b0), .done_data(64'd0),
    .rsp_valid(c_rsp_valid), .rsp_ready(c_rsp_ready), .rsp_data(c_rsp_data)
  );

  amo_fadd_stage #(.MEM_CTRL(1'b1)) dut_mc_i (
    .clk(clk), .rst(rst),
    .req_valid(m_req_valid), .req_ready(m_req_ready), .req_addr(m_req_addr),
    .req_size(m_req_size), .req_addend(m_req_addend),
    .fwd_valid(m_fwd_valid), .fwd_ready(1'b0), .fwd_addr(m_fwd_addr),
    .fwd_size(m_fwd_size), .fwd_addend(m_fwd_addend),
    .up_valid(1'b0), .up_ready(m_up_ready), .up_data(64'd0),
    .inv_valid(m_inv_valid), .inv_ready(m_inv_ready), .inv_addr(m_inv_addr),
    .done_valid(m_done_valid), .done_dirty(m_done_dirty), .done_data(m_done_data),
    .rsp_valid(m_rsp_valid), .rsp_ready(m_rsp_ready), .rsp_data(m_rsp_data)
  );

  // ---------------- bench reference model ----------------
  logic [1:0]  c_state [16];
  logic [63:0] c_data  [64];
  logic [63:0] m_data  [64];

  function automatic logic [63:0] pat(input int i);
    logic [63:0] k;
    k = 64'h0123_4567_89AB_CDEF;
    return 64'(i + 1) * k;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return 1 << sz;
  endfunction

  function automatic logic [63:0] fmask(input logic [1:0] sz);
    if (nbytes(sz) == 8) return '1;
    return (64'd1 << (nbytes(sz) * 8)) - 64'd1;
  endfunction

  function automatic int bitpos(input logic [2:0] off, input logic [1:0] sz);
    return (int'(off) / nbytes(sz)) * nbytes(sz) * 8;
  endfunction

  function automatic logic [63:0] ref_old(input logic [63:0] w, input logic [2:0] off, input logic [1:0] sz);
    return (w >> bitpos(off, sz)) & fmask(sz);
  endfunction

  function automatic logic [63:0] ref_new(input logic [63:0] w, input logic [2:0] off,
                                          input logic [1:0] sz, input logic [63:0] add);
    logic [63:0] s;
    s = (ref_old(w, off, sz) + add) & fmask(sz);
    return (w & ~(fmask(sz) << bitpos(off, sz))) | (s << bitpos(off, sz));
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic pause(input int hi);
    repeat ($urandom_range(0, hi)) @(negedge clk);
  endtask

  // ---------------- cache-mode transaction ----------------
  task automatic cache_txn(input logic [15:0] a, input logic [1:0] sz, input logic [63:0] add, input string lbl);
    int si, di;
    logic hit, wr, saw_fwd;
    logic [63:0] expv, upv;
    si   = int'(a[8:5]);
    di   = si * 4 + int'(a[4:3]);
    hit  = (c_state[si] != 2'd0) && (a[15:9] == 7'(si));
    wr   = hit && (c_state[si] >= 2'd2);
    @(negedge clk);
    c_req_valid = 1; c_req_addr = a; c_req_size = sz; c_req_addend = add;
    while (!c_req_ready) @(negedge clk);
    @(negedge clk);
    c_req_valid = 0;
    chk("R8 ready low while busy", 64'(c_req_ready), 64'd0);
    if (!wr) begin
      while (!c_fwd_valid) @(negedge clk);
      pause(2);
      // R5 shared tag match, R6 miss: forwarded fields unchanged and held (R9)
      chk({lbl, hit ? " R5 fwd addr" : " R6 fwd addr"}, 64'(c_fwd_addr), 64'(a));
      chk({lbl, " R9 fwd held"}, 64'(c_fwd_valid), 64'd1);
      chk({lbl, hit ? " R5 fwd addend" : " R6 fwd addend"}, c_fwd_addend, add);
      chk({lbl, " R6 fwd size"}, 64'(c_fwd_size), 64'(sz));
      c_fwd_ready = 1;
      @(negedge clk);
      c_fwd_ready = 0;
      pause(3);
      upv = {$urandom(), $urandom()};
      c_up_valid = 1; c_up_data = upv;
      while (!c_up_ready) @(negedge clk);
      @(negedge clk);
      c_up_valid = 0;
      if (hit) c_state[si] = 2'd0;
      expv = upv;
    end else begin
      expv = ref_old(c_data[di], a[2:0], sz);
      c_data[di] = ref_new(c_data[di], a[2:0], sz, add);
      c_state[si] = 2'd3;
    end
    saw_fwd = 0;
    while (!c_rsp_valid) begin
      if (c_fwd_valid) saw_fwd = 1;
      @(negedge clk);
    end
    if (wr) chk({lbl, " R2 no forward on writeable hit"}, 64'(saw_fwd), 64'd0);
    pause(2);
    chk({lbl, wr ? " R2/R3 old value" : " R7 passed-back value"}, c_rsp_data, expv);
    c_rsp_ready = 1;
    @(negedge clk);
    c_rsp_ready = 0;
  endtask

  // ---------------- memory-controller transaction ----------------
  task automatic mc_txn(input logic [15:0] a, input logic [1:0] sz, input logic [63:0] add,
                        input logic dirty, input logic [63:0] wb, input string lbl);
    int ix;
    logic [63:0] expv;
    ix = int'(a[8:3]);
    @(negedge clk);
    m_req_valid = 1; m_req_addr = a; m_req_size = sz; m_req_addend = add;
    while (!m_req_ready) @(negedge clk);
    @(negedge clk);
    m_req_valid = 0;
    chk("R8 mc ready low while busy", 64'(m_req_ready), 64'd0);
    while (!m_inv_valid) @(negedge clk);
    chk({lbl, " R10 invalidate address"}, 64'(m_inv_addr), 64'(a));
    pause(2);
    m_inv_ready = 1;
    @(negedge clk);
    m_inv_ready = 0;
    repeat (2) @(negedge clk);
    chk({lbl, " R10 no response before completion"}, 64'(m_rsp_valid), 64'd0);
    m_done_valid = 1; m_done_dirty = dirty; m_done_data = wb;
    @(negedge clk);
    m_done_valid = 0; m_done_dirty = 0;
    if (dirty) m_data[ix] = wb;
    expv = ref_old(m_data[ix], a[2:0], sz);
    m_data[ix] = ref_new(m_data[ix], a[2:0], sz, add);
    while (!m_rsp_valid) @(negedge clk);
    pause(1);
    chk({lbl, dirty ? " R10/R11 old value after writeback" : " R11 old value"}, m_rsp_data, expv);
    m_rsp_ready = 1;
    @(negedge clk);
    m_rsp_ready = 0;
  endtask

  function automatic logic [15:0] mk_addr(input int tg, input int set, input int wd, input int by);
    return {7'(tg), 4'(set), 2'(wd), 3'(by)};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 16; s++) c_state[s] = 2'(s % 4);
    for (int i = 0; i < 64; i++) begin
      c_data[i] = pat(i);
      m_data[i] = pat(i);
    end
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (10) @(negedge clk);
    chk("R1 ready low during preload", 64'(c_req_ready), 64'd0);
    chk("R1 mc ready low during preload", 64'(m_req_ready), 64'd0);
    repeat (60) @(negedge clk);
    chk("R1 ready after preload", 64'(c_req_ready), 64'd1);
    chk("R1 mc ready after preload", 64'(m_req_ready), 64'd1);

    // directed cache-mode cases
    cache_txn(mk_addr(2, 2, 1, 0), 2'd3, 64'd0, "R1 exclusive preload");
    cache_txn(mk_addr(2, 2, 1, 0), 2'd3, 64'd5, "R4 repeat add");
    cache_txn(mk_addr(2, 2, 1, 0), 2'd3, 64'd0, "R4 sees update");
    cache_txn(mk_addr(3, 3, 0, 7), 2'd0, 64'hFF, "R3 byte wrap");
    cache_txn(mk_addr(3, 3, 0, 0), 2'd3, 64'd0, "R3 neighbours intact");
    cache_txn(mk_addr(7, 7, 2, 3), 2'd1, 64'hFFFF_FFFF_FFFF_0001, "R3 halfword align");
    cache_txn(mk_addr(7, 7, 2, 5), 2'd2, 64'h8000_0000, "R3 word align");
    cache_txn(mk_addr(1, 1, 0, 0), 2'd2, 64'd9, "R5 shared");
    cache_txn(mk_addr(1, 1, 0, 0), 2'd2, 64'd9, "R5 after invalidate");
    cache_txn(mk_addr(0, 0, 3, 0), 2'd3, 64'd1, "R6 invalid line");
    cache_txn(mk_addr(9, 6, 1, 0), 2'd3, 64'd1, "R6 tag mismatch");
    cache_txn(mk_addr(9, 6, 1, 0), 2'd3, 64'd1, "R6 no allocate");
    cache_txn(mk_addr(6, 6, 1, 0), 2'd3, 64'd0, "R2 line untouched by miss");

    for (int n = 0; n < 150; n++) begin
      int s, tg;
      s  = int'($urandom_range(0, 15));
      tg = ($urandom_range(0, 9) < 7) ? s : int'($urandom_range(0, 127));
      cache_txn(mk_addr(tg, s, int'($urandom_range(0, 3)), int'($urandom_range(0, 7))),
                2'($urandom_range(0, 3)), {$urandom(), $urandom()}, "R2 random");
    end

    // directed memory-controller cases
    mc_txn(16'h0008, 2'd3, 64'd3, 1'b0, 64'd0, "R11 clean");
    mc_txn(16'h0008, 2'd3, 64'd0, 1'b0, 64'd0, "R11 sees update");
    mc_txn(16'h0010, 2'd2, 64'd1, 1'b1, 64'h1111_2222_FFFF_FFFF, "R10 dirty");
    mc_txn(16'h0010, 2'd3, 64'd0, 1'b0, 64'd0, "R10 wrapped word kept");
    mc_txn(16'h01F8, 2'd0, 64'hFF, 1'b0, 64'd0, "R3 mc byte");
    for (int n = 0; n < 60; n++) begin
      mc_txn({7'($urandom_range(0, 127)), 6'($urandom_range(0, 63)), 3'($urandom_range(0, 7))},
             2'($urandom_range(0, 3)), {$urandom(), $urandom()}, 1'($urandom_range(0, 1)),
             {$urandom(), $urandom()}, "R11 random");
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule